// File: doc/BRIEF.md
# ECC error event logging buffer

This block records memory ECC error events into a fixed-depth log that software reads through a small word-addressed register window. An event is presented on the capture port as a one-cycle valid pulse. It carries a 4-bit error type code, a 38-bit error address, a 7-bit source transaction ID, a 5-bit instance ID and a 3-bit IP type tag. The block packs each accepted event into a two-word entry and stores it in the next free slot. An entry counter tracks how many slots hold valid entries.

When the log is full, an event is not stored. It is also not discarded without a trace: it sets a sticky flag in a 16-bit overflow field, and the flag it sets is chosen by its error type. Software can therefore tell which kinds of error were lost. A clear command empties the log and wipes the overflow field. The read port is combinational and has no side effects.

Top module: `ecc_event_log`

## Requirements
- R1: After reset, the status word reads zero and every entry word reads zero.
- R2: An event that arrives while the counter is below 16 is stored in the slot whose index equals the counter, and the counter increments by one.
- R3: Word 1 of an entry holds the address bits [37:32] in [5:0], the type code in [9:6], the source ID in [16:10], the instance ID in [21:17] and the IP type in [24:22]. Bits [31:25] read as zero.
- R4: Word 2 of an entry holds the address bits [31:0].
- R5: An event that arrives while the counter equals 16 is not stored and leaves the counter at 16. It ORs the value 1 shifted left by its type code into the overflow field, and overflow bits already set remain set.
- R6: A clear pulse sets the counter to zero and the overflow field to zero.
- R7: If a clear and an event arrive in the same cycle, the clear is applied first and the event is then stored as entry 0, which leaves the counter at 1.
- R8: The status word is at byte offset 0x300. It holds the counter in [4:0] and the overflow field in [31:16]; every other bit reads zero.
- R9: Entry k is at byte offset 0x310 + 8*k, with word 1 at that offset and word 2 four bytes higher.
- R10: Entries at or above the counter read as zero. Offsets outside the status word and the entry range read as zero, and so do offsets that are not a multiple of 4.
- R11: A valid pulse is accepted on every clock, so events on consecutive cycles are each logged in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_type | input | 4 | Error type code |
| evt_addr | input | 38 | Error address |
| evt_src | input | 7 | Source transaction ID |
| evt_inst | input | 5 | Instance ID |
| evt_iptype | input | 3 | IP type tag |
| clr | input | 1 | Clear command pulse |
| rd_addr | input | 12 | Byte offset of the read word |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
The bench builds the block with its default parameters: a depth of 16, a 12-bit read offset, the status word at 0x300 and the entries from 0x310. With these values, filling the log and then overflowing it takes only a few dozen cycles. The full-log boundary, the sticky OR of several type flags (including the top code 1101), and a clear that coincides with an event are therefore all exercised directly. Every entry word is also read back in each scenario, together with offsets just outside the window.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int TYPE_W = 4;
  localparam int FLAG_W = 16;
  localparam int EADDR_W = 38;

  // Header word: addr[37:32] | type | source | instance | ip type, bits 31:25 zero
  function automatic logic [31:0] pack_head(input logic [5:0] a_hi, input logic [3:0] t,
                                            input logic [6:0] src, input logic [4:0] inst,
                                            input logic [2:0] ipt);
    logic [31:0] w;
    w = '0;
    w[5:0]   = a_hi;
    w[9:6]   = t;
    w[16:10] = src;
    w[21:17] = inst;
    w[24:22] = ipt;
    return w;
  endfunction

  // One-hot loss flag selected by the error type code
  function automatic logic [FLAG_W-1:0] type_flag(input logic [TYPE_W-1:0] t);
    return FLAG_W'(1) << t;
  endfunction
endpackage

// File: rtl/ecc_log_store.sv
module ecc_log_store #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_valid,
  input  logic                   clr,
  input  logic [31:0]            evt_head,
  input  logic [31:0]            evt_tail,
  output logic [CNT_W-1:0]       count_q,
  output logic                   accept,
  output logic                   full_now,
  output logic [DEPTH-1:0][31:0] head_q,
  output logic [DEPTH-1:0][31:0] tail_q
);
  logic [CNT_W-1:0] base_cnt;

  // The clear acts before the event of the same cycle
  always_comb begin
    base_cnt = clr ? '0 : count_q;
    full_now = (base_cnt == CNT_W'(DEPTH));
    accept   = evt_valid && !full_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      count_q <= base_cnt + CNT_W'(accept);
      if (accept) begin
        head_q[base_cnt[IDX_W-1:0]] <= evt_head;
        tail_q[base_cnt[IDX_W-1:0]] <= evt_tail;
      end
    end
  end
endmodule

// File: rtl/ecc_log_overflow.sv
module ecc_log_overflow
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              reject,
  input  logic [TYPE_W-1:0] evt_type,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] kept;
  logic [FLAG_W-1:0] add;

  always_comb begin
    kept = clr ? '0 : flags_q;
    add  = reject ? type_flag(evt_type) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= kept | add;
  end
endmodule

// File: rtl/ecc_log_readmux.sv
module ecc_log_readmux
  import ecc_log_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CNT_W      = 5,
  parameter int IDX_W      = 4,
  parameter int RD_AW      = 12,
  parameter int STATUS_OFF = 'h300,
  parameter int ENTRY_BASE = 'h310
) (
  input  logic [RD_AW-1:0]       rd_addr,
  input  logic [CNT_W-1:0]       count,
  input  logic [FLAG_W-1:0]      ovf,
  input  logic [DEPTH-1:0][31:0] head_q,
  input  logic [DEPTH-1:0][31:0] tail_q,
  output logic [31:0]            rd_data
);
  localparam int ENTRY_END = ENTRY_BASE + DEPTH * 8;

  logic [RD_AW-1:0] off;
  logic [IDX_W-1:0] idx;
  logic             in_entries;

  always_comb begin
    off        = rd_addr - RD_AW'(ENTRY_BASE);
    idx        = IDX_W'(off >> 3);
    in_entries = (rd_addr >= RD_AW'(ENTRY_BASE)) && (rd_addr < RD_AW'(ENTRY_END));
    rd_data    = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr == RD_AW'(STATUS_OFF)) begin
        rd_data = {ovf, 16'(count)};
      end else if (in_entries && (CNT_W'(idx) < count)) begin
        rd_data = off[2] ? tail_q[idx] : head_q[idx];
      end
    end
  end
endmodule

// File: rtl/ecc_event_log.sv
module ecc_event_log
  import ecc_log_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int RD_AW      = 12,
  parameter int STATUS_OFF = 'h300,
  parameter int ENTRY_BASE = 'h310
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_valid,
  input  logic [3:0]   evt_type,
  input  logic [37:0]  evt_addr,
  input  logic [6:0]   evt_src,
  input  logic [4:0]   evt_inst,
  input  logic [2:0]   evt_iptype,
  input  logic         clr,
  input  logic [RD_AW-1:0] rd_addr,
  output logic [31:0]  rd_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, observed by the bound checker
  logic [CNT_W-1:0]       count_q;
  logic [FLAG_W-1:0]      ovf_q;
  logic                   accept;
  logic                   full_now;
  logic                   reject;
  logic [31:0]            evt_head;
  logic [31:0]            evt_tail;
  logic [DEPTH-1:0][31:0] head_q;
  logic [DEPTH-1:0][31:0] tail_q;

  always_comb begin
    evt_head = pack_head(evt_addr[37:32], evt_type, evt_src, evt_inst, evt_iptype);
    evt_tail = evt_addr[31:0];
    reject   = evt_valid && full_now;
  end

  ecc_log_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .clr(clr),
    .evt_head(evt_head), .evt_tail(evt_tail), .count_q(count_q),
    .accept(accept), .full_now(full_now), .head_q(head_q), .tail_q(tail_q)
  );

  ecc_log_overflow u_ovf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .reject(reject),
    .evt_type(evt_type), .flags_q(ovf_q)
  );

  ecc_log_readmux #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .RD_AW(RD_AW),
    .STATUS_OFF(STATUS_OFF), .ENTRY_BASE(ENTRY_BASE)
  ) u_rd (
    .rd_addr(rd_addr), .count(count_q), .ovf(ovf_q),
    .head_q(head_q), .tail_q(tail_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/ecc_event_log_props.sv
module ecc_event_log_props #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic [3:0]       evt_type,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic [15:0]      ovf
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_accept_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt_valid && count < CNT_W'(DEPTH)) |=> (count == CNT_W'($past(count) + 1)));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((ovf & $past(ovf)) == $past(ovf)));

  p_ovf_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count < CNT_W'(DEPTH)) |=> (ovf == $past(ovf)));

  p_reject_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt_valid && count == CNT_W'(DEPTH)) |=> ovf[$past(evt_type)]);

  p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt_valid) |=> (count == '0 && ovf == '0));

  p_clear_then_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt_valid) |=> (count == CNT_W'(1) && ovf == '0));
endmodule

bind ecc_event_log ecc_event_log_props #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
  .clr(clr), .count(count_q), .ovf(ovf_q)
);

// File: tb/ecc_event_log_test.sv
module ecc_event_log_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [3:0]  evt_type = '0;
  logic [37:0] evt_addr = '0;
  logic [6:0]  evt_src = '0;
  logic [4:0]  evt_inst = '0;
  logic [2:0]  evt_iptype = '0;
  logic        clr = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_head [16];
  logic [31:0] m_tail [16];
  int          m_cnt;
  logic [15:0] m_ovf;

  always #10 clk = ~clk;

  ecc_event_log uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_addr(evt_addr), .evt_src(evt_src), .evt_inst(evt_inst),
    .evt_iptype(evt_iptype), .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #2;
    d = rd_data;
  endtask

  // Compare status and every entry word against the bench model
  task automatic check_model(input string req);
    logic [31:0] d;
    rd(12'h300, d);
    check({req, " R8 status"}, d, {m_ovf, 11'b0, 5'(m_cnt)});
    for (int k = 0; k < 16; k++) begin
      rd(12'(12'h310 + 8 * k), d);
      check({req, " R9 R10 word1"}, d, (k < m_cnt) ? m_head[k] : 32'h0);
      rd(12'(12'h314 + 8 * k), d);
      check({req, " R9 R10 word2"}, d, (k < m_cnt) ? m_tail[k] : 32'h0);
    end
  endtask

  function automatic logic [31:0] head_of(input logic [3:0] t, input logic [37:0] a,
                                          input logic [6:0] s, input logic [4:0] i,
                                          input logic [2:0] p);
    return {7'b0, p, i, s, t, a[37:32]};
  endfunction

  task automatic model_evt(input logic [3:0] t, input logic [37:0] a, input logic [6:0] s,
                           input logic [4:0] i, input logic [2:0] p);
    if (m_cnt < 16) begin
      m_head[m_cnt] = head_of(t, a, s, i, p);
      m_tail[m_cnt] = a[31:0];
      m_cnt++;
    end else begin
      m_ovf[t] = 1'b1;
    end
  endtask

  // Drives a one-cycle pulse; consecutive calls give back-to-back events
  task automatic send(input logic [3:0] t, input logic [37:0] a, input logic [6:0] s,
                      input logic [4:0] i, input logic [2:0] p, input bit with_clr);
    evt_type = t; evt_addr = a; evt_src = s; evt_inst = i; evt_iptype = p;
    evt_valid = 1'b1;
    clr = with_clr;
    if (with_clr) begin m_cnt = 0; m_ovf = '0; end
    model_evt(t, a, s, i, p);
    @(negedge clk);
    evt_valid = 1'b0;
    clr = 1'b0;
  endtask

  function automatic logic [3:0] code_at(input int k);
    logic [3:0] codes [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD};
    return codes[k % 10];
  endfunction

  task automatic send_k(input int k);
    send(code_at(k), {6'(k * 5 + 1), 32'hA5A5_0000 ^ (32'h0101_0101 * k)},
         7'(k * 9 + 3), 5'(k * 7), 3'(k), 1'b0);
  endtask

  task automatic t_reset;
    check_model("R1 reset");
  endtask

  task automatic t_fill;
    @(negedge clk);
    for (int k = 0; k < 3; k++) send_k(k);
    check_model("R2 R3 R4 partial");
    @(negedge clk);
    for (int k = 3; k < 16; k++) send_k(k);
    check_model("R2 R11 full");
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    @(negedge clk);
    send(4'h2, 38'h3F_FFFF_FFFF, 7'h7F, 5'h1F, 3'h7, 1'b0);
    send(4'hD, 38'h0, 7'h0, 5'h0, 3'h0, 1'b0);
    send(4'h2, 38'h1, 7'h1, 5'h1, 3'h1, 1'b0);
    rd(12'h300, d);
    check("R5 flags", d, {16'h2004, 16'd16});
    check_model("R5 entries kept");
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_cnt = 0; m_ovf = '0;
    check_model("R6 R10 cleared");
  endtask

  task automatic t_clear_with_event;
    @(negedge clk);
    for (int k = 4; k < 8; k++) send_k(k);
    send(4'hB, 38'h2A_1234_5678, 7'h55, 5'h0A, 3'h5, 1'b1);
    check_model("R7 clear+event");
  endtask

  task automatic t_window;
    logic [31:0] d;
    rd(12'h304, d);  check("R10 gap", d, 32'h0);
    rd(12'h30C, d);  check("R10 gap", d, 32'h0);
    rd(12'h311, d);  check("R10 unaligned", d, 32'h0);
    rd(12'h302, d);  check("R10 unaligned status", d, 32'h0);
    rd(12'h390, d);  check("R10 past end", d, 32'h0);
    rd(12'h2FC, d);  check("R10 below", d, 32'h0);
    rd(12'h310, d);  check("R3 head after window reads", d, m_head[0]);
    rd(12'h300, d);  check("R8 status after window reads", d, {m_ovf, 11'b0, 5'(m_cnt)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_cnt = 0;
    m_ovf = '0;
    for (int k = 0; k < 16; k++) begin m_head[k] = '0; m_tail[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_overflow();
    t_clear();
    t_clear_with_event();
    t_window();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule